// File: doc/BRIEF.md
# Serial Port Status and Data Register Front End

This block is the register-facing side of a serial port. It holds five event flags (clear-to-send change, break seen, transmit buffer empty, transmission finished, receive byte waiting) and the most recently received byte. It presents them on a simple 32-bit word bus with read and write strobes.

Hardware event pulses from the serial engine set the flags. Software bus accesses clear them, and each flag has its own clear rule. A write to the data register is passed straight out to the transmitter as a one-cycle strobe with its byte. The CTS line is asynchronous, so it is resynchronised before its edges are detected.

Read data is combinational from the current register state while the read strobe is high. The side effects of an access (clears, arming, capture) take effect at the clock edge that ends the access cycle. The address is a byte address. Its two low bits are ignored. The status word sits at offset 0x00 and the data word at offset 0x04.

Top module: `sp_stat_regs`

## Requirements
- R1: After reset the status word reads 0x000000C0 (bits 7 and 6 set) and the data word reads 0.
- R2: Status bits 31..10 and 4..0 always read 0. Data reads return the received byte in bits 7..0 and 0 above. Addresses other than offsets 0x00 and 0x04 read 0.
- R3: Status bits 9 and 8 are write-zero-to-clear. Writing 1 to them leaves them unchanged.
- R4: Bit 7 (transmit buffer empty) is set by the transmit-load pulse. It is cleared by any data write, and status writes never change it.
- R5: Bit 6 (transmission finished) is set by the transmit-done pulse and cleared by writing 0 to it in a status write.
- R6: A status read that sees bit 6 at 1 arms a latch. The next data write then clears bit 6. A data write with no armed latch leaves bit 6 alone.
- R7: A transmit-done pulse that arrives between the arming status read and the data write disarms the latch, so bit 6 stays 1.
- R8: The receive-ready pulse captures the byte and sets bit 5. A data read clears bit 5 and returns the captured byte, and writing 0 to bit 5 also clears it.
- R9: When a hardware set and a software clear of the same flag fall in one cycle, the flag ends up 1.
- R10: CTS passes through two synchroniser stages. A level change is first visible in bit 9 after the third rising clock edge following it.
- R11: A data write produces a one-cycle strobe, in the same cycle, carrying write-data bits 7..0. No other access produces it.
- R12: Writes to unmapped addresses change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| ev_tx_load | input | 1 | Pulse: buffered byte moved into the shifter |
| ev_tx_done | input | 1 | Pulse: frame fully shifted out |
| ev_rx_valid | input | 1 | Pulse: received byte ready |
| ev_rx_byte | input | 8 | Received byte, qualified by ev_rx_valid |
| ev_break | input | 1 | Pulse: break frame detected |
| cts_line | input | 1 | Raw asynchronous CTS level |
| txd_wr_stb | output | 1 | Strobe: software wrote the data register |
| txd_wr_byte | output | 8 | Byte written, qualified by txd_wr_stb |

## Verification
The collision that matters is a hardware event pulse landing in the same clock cycle as the software access that would clear the same flag. The bench provokes it in several forms: a status write of zeros issued together with the break, done and receive pulses; a data write together with the transmit-load pulse; and a data read together with a new received byte. It also times a CTS toggle so that its detected edge lands on the clearing write. In every case the flag must read back as 1, and the data read must return the old byte while the new one is kept. A sweep over all 32 write patterns of bits 9..5, with every flag first forced to 1, judges the write-zero rules and the read-only bit arithmetically.

// File: rtl/sp_stat_pkg.sv
package sp_stat_pkg;

    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int FLAG_LSB = 5;
    localparam int FLAG_N   = 5;
    localparam int FLAG_MSB = FLAG_LSB + FLAG_N - 1;

    // Packed so that the MSB lands on status bit 9 and the LSB on bit 5.
    typedef struct packed {
        logic cts_chg;
        logic brk;
        logic tx_empty;
        logic tx_done;
        logic rx_full;
    } flags_t;

    typedef struct packed {
        flags_t              fl;
        logic                tdc_armed;
        logic [BYTE_W-1:0]   rx_byte;
    } core_st_t;

    localparam flags_t FLAGS_RST = '{cts_chg: 1'b0, brk: 1'b0, tx_empty: 1'b1,
                                     tx_done: 1'b1, rx_full: 1'b0};

endpackage

// File: rtl/sp_bus_dec.sv
module sp_bus_dec #(
    parameter int ADDR_W   = 8,
    parameter int STAT_OFS = 0,
    parameter int DATA_OFS = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              stat_rd,
    output logic              stat_wr,
    output logic              data_rd,
    output logic              data_wr
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] STAT_WA = WA_W'(STAT_OFS >> 2);
    localparam logic [WA_W-1:0] DATA_WA = WA_W'(DATA_OFS >> 2);

    logic [WA_W-1:0] word_a;
    logic            hit_stat;
    logic            hit_data;
    logic            unused_lsb;

    assign word_a     = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];

    always_comb begin
        hit_stat = (word_a == STAT_WA);
        hit_data = (word_a == DATA_WA);
        stat_rd  = bus_rd & hit_stat;
        stat_wr  = bus_wr & hit_stat;
        data_rd  = bus_rd & hit_data;
        data_wr  = bus_wr & hit_data;
    end
endmodule

// File: rtl/sp_cts_sync.sv
module sp_cts_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_line,
    output logic cts_lvl,
    output logic cts_edge
);
    // STAGES synchroniser flops plus one history flop for edge detection.
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], cts_line};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CHAIN_W{IDLE}};
        else        chain_q <= chain_d;
    end

    assign cts_lvl  = chain_q[STAGES-1];
    assign cts_edge = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/sp_flag_core.sv
module sp_flag_core
    import sp_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  flags_t            wr_bits,
    input  logic              ev_tx_load,
    input  logic              ev_tx_done,
    input  logic              ev_rx_valid,
    input  logic [BYTE_W-1:0] ev_rx_byte,
    input  logic              ev_break,
    input  logic              cts_edge,
    output flags_t            flags,
    output logic [BYTE_W-1:0] rx_byte
);
    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // Software clears first; hardware sets below override them.
        if (stat_wr) begin
            if (!wr_bits.cts_chg) st_d.fl.cts_chg = 1'b0;
            if (!wr_bits.brk)     st_d.fl.brk     = 1'b0;
            if (!wr_bits.tx_done) st_d.fl.tx_done = 1'b0;
            if (!wr_bits.rx_full) st_d.fl.rx_full = 1'b0;
        end
        if (data_wr) begin
            st_d.fl.tx_empty = 1'b0;
            if (st_q.tdc_armed) st_d.fl.tx_done = 1'b0;
        end
        if (data_rd) st_d.fl.rx_full = 1'b0;

        // Read-then-write latch for the transmission-finished flag.
        if (stat_rd && st_q.fl.tx_done)     st_d.tdc_armed = 1'b1;
        if (data_wr)                        st_d.tdc_armed = 1'b0;
        if (stat_wr && !wr_bits.tx_done)    st_d.tdc_armed = 1'b0;
        if (ev_tx_done)                     st_d.tdc_armed = 1'b0;

        // Hardware sets win over same-cycle clears.
        if (cts_edge)    st_d.fl.cts_chg  = 1'b1;
        if (ev_break)    st_d.fl.brk      = 1'b1;
        if (ev_tx_load)  st_d.fl.tx_empty = 1'b1;
        if (ev_tx_done)  st_d.fl.tx_done  = 1'b1;
        if (ev_rx_valid) begin
            st_d.fl.rx_full = 1'b1;
            st_d.rx_byte    = ev_rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fl        <= FLAGS_RST;
            st_q.tdc_armed <= 1'b0;
            st_q.rx_byte   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags   = st_q.fl;
    assign rx_byte = st_q.rx_byte;
endmodule

// File: rtl/sp_stat_regs.sv
module sp_stat_regs
    import sp_stat_pkg::*;
#(
    parameter int   ADDR_W      = 8,
    parameter int   STAT_OFS    = 0,
    parameter int   DATA_OFS    = 4,
    parameter int   SYNC_STAGES = 2,
    parameter logic CTS_IDLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_tx_load,
    input  logic              ev_tx_done,
    input  logic              ev_rx_valid,
    input  logic [7:0]        ev_rx_byte,
    input  logic              ev_break,
    input  logic              cts_line,
    output logic              txd_wr_stb,
    output logic [7:0]        txd_wr_byte
);
    logic              stat_rd, stat_wr, data_rd, data_wr;
    logic              cts_lvl, cts_edge;
    flags_t            flags;
    flags_t            wr_bits;
    logic [FLAG_N-1:0] flags_w;
    logic [BYTE_W-1:0] rx_byte;
    logic              unused_bits;

    assign wr_bits     = flags_t'(bus_wdata[FLAG_MSB:FLAG_LSB]);
    assign flags_w     = flags;
    assign unused_bits = ^{bus_wdata[BUS_W-1:FLAG_MSB+1], cts_lvl};

    sp_bus_dec #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .stat_rd  (stat_rd),
        .stat_wr  (stat_wr),
        .data_rd  (data_rd),
        .data_wr  (data_wr)
    );

    sp_cts_sync #(
        .STAGES (SYNC_STAGES),
        .IDLE   (CTS_IDLE)
    ) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_line (cts_line),
        .cts_lvl  (cts_lvl),
        .cts_edge (cts_edge)
    );

    sp_flag_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_rd     (stat_rd),
        .stat_wr     (stat_wr),
        .data_rd     (data_rd),
        .data_wr     (data_wr),
        .wr_bits     (wr_bits),
        .ev_tx_load  (ev_tx_load),
        .ev_tx_done  (ev_tx_done),
        .ev_rx_valid (ev_rx_valid),
        .ev_rx_byte  (ev_rx_byte),
        .ev_break    (ev_break),
        .cts_edge    (cts_edge),
        .flags       (flags),
        .rx_byte     (rx_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (stat_rd)      bus_rdata[FLAG_MSB:FLAG_LSB] = flags;
        else if (data_rd) bus_rdata[BYTE_W-1:0]        = rx_byte;
    end

    assign txd_wr_stb  = data_wr;
    assign txd_wr_byte = bus_wdata[BYTE_W-1:0];
endmodule

// File: rtl/sp_stat_regs_chk.sv
module sp_stat_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        ev_tx_load,
    input logic        ev_tx_done,
    input logic        ev_rx_valid,
    input logic        ev_break,
    input logic        txd_wr_stb,
    input logic [4:0]  flags
);
    // flags: [4] cts change, [3] break, [2] tx empty, [1] tx done, [0] rx full

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_rdata[31:10] == 22'd0));

    p_tx_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!txd_wr_stb && !ev_tx_load) |=> $stable(flags[2]));

    p_tx_empty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_load |=> flags[2]);

    p_tx_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> flags[1]);

    p_rx_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_valid |=> flags[0]);

    p_break_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_break |=> flags[3]);

    p_strobe_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr_stb |-> bus_wr);

    p_break_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(ev_break));
endmodule

bind sp_stat_regs sp_stat_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .ev_tx_load  (ev_tx_load),
    .ev_tx_done  (ev_tx_done),
    .ev_rx_valid (ev_rx_valid),
    .ev_break    (ev_break),
    .txd_wr_stb  (txd_wr_stb),
    .flags       (flags_w)
);

// File: tb/test_sp_stat_regs.sv
module test_sp_stat_regs;
    localparam logic [7:0] A_STAT = 8'h00;
    localparam logic [7:0] A_DATA = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_tx_load = 0, ev_tx_done = 0, ev_rx_valid = 0, ev_break = 0;
    logic [7:0]  ev_rx_byte = '0;
    logic        cts_line = 1'b1;
    logic        txd_wr_stb;
    logic [7:0]  txd_wr_byte;

    int checks = 0, failures = 0;
    bit done = 0;
    logic        last_stb;
    logic [7:0]  last_byte;
    logic [31:0] rv;

    always #5 clk = ~clk;

    sp_stat_regs i_sp_stat_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done),
        .ev_rx_valid(ev_rx_valid), .ev_rx_byte(ev_rx_byte), .ev_break(ev_break),
        .cts_line(cts_line), .txd_wr_stb(txd_wr_stb), .txd_wr_byte(txd_wr_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        #1 last_stb = txd_wr_stb; last_byte = txd_wr_byte;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input bit ld, input bit dn, input bit rx, input logic [7:0] b, input bit br);
        ev_tx_load = ld; ev_tx_done = dn; ev_rx_valid = rx; ev_rx_byte = b; ev_break = br;
        cyc();
        ev_tx_load = 0; ev_tx_done = 0; ev_rx_valid = 0; ev_break = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values (this status read arms the TDC latch)
        rd(A_STAT, rv); chk("R1 status reset", rv, 32'h0000_00C0);
        rd(A_DATA, rv); chk("R1 data reset", rv, 32'h0);

        // R11 data write strobe; R6 armed clear; R4 empty cleared
        wr(A_DATA, 32'hFFFF_01A5);
        chk("R11 strobe on data write", {31'b0, last_stb}, 32'h1);
        chk("R11 byte on data write", {24'b0, last_byte}, 32'hA5);
        rd(A_STAT, rv); chk("R4 R6 after armed data write", rv, 32'h0);
        wr(A_STAT, 32'h0);
        chk("R11 no strobe on status write", {31'b0, last_stb}, 32'h0);

        // R5 set by done pulse; R7 disarm by second pulse
        pulse(0, 1, 0, 8'h00, 0);
        rd(A_STAT, rv); chk("R5 done set", rv, 32'h40);
        pulse(0, 1, 0, 8'h00, 0);
        wr(A_DATA, 32'h12);
        rd(A_STAT, rv); chk("R7 disarmed by done pulse", rv, 32'h40);
        wr(A_STAT, 32'hFFFF_FFBF);
        rd(A_STAT, rv); chk("R5 write zero clears done", rv, 32'h0);

        // R6 write without prior read does not clear
        pulse(0, 1, 0, 8'h00, 0);
        wr(A_DATA, 32'h34);
        rd(A_STAT, rv); chk("R6 no read no clear", rv, 32'h40);
        wr(A_DATA, 32'h56);
        rd(A_STAT, rv); chk("R6 read then write clears", rv, 32'h0);

        // R4 load sets empty; status write cannot clear it
        pulse(1, 0, 0, 8'h00, 0);
        rd(A_STAT, rv); chk("R4 load sets empty", rv, 32'h80);
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); chk("R4 read-only bit 7", rv, 32'h80);

        // R8 receive sweep
        for (int b = 1; b < 256; b += 37) begin
            pulse(0, 0, 1, 8'(b), 0);
            rd(A_STAT, rv); chk("R8 rx flag set", rv, 32'hA0);
            rd(A_DATA, rv); chk("R8 R2 rx byte", rv, 32'(b));
            rd(A_STAT, rv); chk("R8 data read clears", rv, 32'h80);
        end
        pulse(0, 0, 1, 8'h99, 0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); chk("R8 write zero clears rx", rv, 32'h80);

        // R10 CTS synchroniser latency
        cts_line = 1'b0;
        cyc(); cyc();
        rd(A_STAT, rv); chk("R10 not before third edge", rv, 32'h80);
        rd(A_STAT, rv); chk("R10 after third edge", rv, 32'h280);
        wr(A_STAT, 32'h200);
        rd(A_STAT, rv); chk("R3 write one keeps cts flag", rv, 32'h280);
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); chk("R3 write zero clears cts flag", rv, 32'h80);

        // R3 R4 R5 R8 sweep of all write patterns over bits 9..5
        for (int p = 0; p < 32; p++) begin
            logic [4:0] pb;
            pb = 5'(p);
            cts_line = ~cts_line;
            pulse(1, 1, 1, 8'h3C, 1);
            cyc(); cyc();
            wr(A_STAT, 32'hFFFF_FC1F | (32'(pb) << 5));
            rd(A_STAT, rv);
            chk("R3 R5 R8 R4 write pattern sweep", rv,
                32'({pb[4], pb[3], 1'b1, pb[1], pb[0]}) << 5);
        end
        wr(A_STAT, 32'h0);

        // R9 set wins over clear, all flags
        cts_line = ~cts_line;
        cyc(); cyc();
        ev_break = 1; ev_tx_done = 1; ev_rx_valid = 1; ev_rx_byte = 8'h77;
        wr(A_STAT, 32'h0);
        ev_break = 0; ev_tx_done = 0; ev_rx_valid = 0;
        rd(A_STAT, rv); chk("R9 sets win over status clear", rv, 32'h3E0);
        ev_tx_load = 1;
        wr(A_DATA, 32'h0);
        ev_tx_load = 0;
        rd(A_STAT, rv); chk("R9 load wins over data write R6", rv, 32'h3A0);
        ev_rx_valid = 1; ev_rx_byte = 8'h55;
        rd(A_DATA, rv); chk("R9 old byte returned", rv, 32'h77);
        ev_rx_valid = 0;
        rd(A_STAT, rv); chk("R9 rx wins over data read", rv, 32'h3A0);
        rd(A_DATA, rv); chk("R9 new byte kept", rv, 32'h55);

        // R12 unmapped accesses
        wr(8'h08, 32'h0);
        chk("R12 no strobe unmapped", {31'b0, last_stb}, 32'h0);
        rd(A_STAT, rv); chk("R12 unmapped write ignored", rv, 32'h380);
        rd(8'h08, rv); chk("R2 unmapped reads zero", rv, 32'h0);
        rd(8'h0C, rv); chk("R2 unmapped reads zero", rv, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule